// File: doc/BRIEF.md
# Type-Banked Scratchpad Address Generator

The block forms the effective memory address for short memory-reference instructions that run in the scratchpad modes. It holds three banks of eight base registers, one bank for direct operands, one for parameter pointers and one for array pointers. The instruction never names a base register: the kind of addressing picks the bank, and the operand type code picks the register inside that bank. The short element index is scaled by the element size (direct) or by the pointer size (indirect kinds) and added to that base.

Direct accesses finish one cycle after acceptance. Pointer-indirect and post-indexed accesses first read a pointer through a valid/ready request port with a separate response strobe. The block stays busy until the pointer comes back and then presents the final address, with one of three 32-bit index registers added in the post-indexed case. In register scratchpad mode a direct access produces a supplementary-register number rather than an address. Narrow modes reject the types they cannot encode.

Top module: `spad_agen`

## Requirements
- R1: Kind code 0 reads the direct bank, 1 the pointer bank and 2 the array bank. Within the bank, the 3-bit type code (0 byte, 1 halfword, 2 integer, 3 long, 4 medium, 5 floating, 6 double, 7 quad) picks the register.
- R2: Mode codes 0 (stateless) and 3 (register scratchpad) use only index bits [5:0], so 64 elements. Mode codes 1 (stateful) and 2 (mutable) use all 8 index bits, so 256 elements.
- R3: A direct access yields base + index * size. The byte sizes by type code 0..7 are 1, 2, 4, 8, 6, 4, 8, 16. done_o rises in the cycle after acceptance and no fetch is issued.
- R4: A pointer-indirect access requests a read at pointer-bank base + index * (wide_ptr_i ? 8 : 4). mem_req_valid_o stays high with a stable address until mem_req_ready_i. The returned pointer becomes the final address.
- R5: A post-indexed access fetches from array-bank base + index * pointer size. It then adds the zero-extended index register picked by ix_sel_i (1, 2 or 3; value 0 adds nothing).
- R6: dest_o equals the 2-bit dest_i field for direct accesses and is 0 for both indirect kinds.
- R7: In mode 3 a direct access sets supp_o, gives supp_idx_o = index[5:0] and issues no fetch. Indirect kinds in mode 3 still use memory.
- R8: Kind 3, or modes 0 and 3 with type 3, 4 or 7, completes the next cycle with done_o and err_o and issues no fetch.
- R9: busy_o is high from acceptance of an indirect access until its result. Requests arriving while busy are ignored. done_o is a single-cycle pulse.
- R10: With wide_ptr_i low, only the low 32 bits of mem_rsp_data_i form the pointer, zero-extended. With wide_ptr_i high, all 64 bits are used.
- R11: A bank write (wr_bank_i, wr_type_i, wr_data_i) is seen by a request in the same cycle or the next cycle.
- R12: After reset busy_o, done_o and mem_req_valid_o are 0 and every bank register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bank register write strobe |
| wr_bank_i | input | 2 | Bank to write (0 direct, 1 pointer, 2 array) |
| wr_type_i | input | 3 | Register within bank |
| wr_data_i | input | AW | Write data |
| req_valid_i | input | 1 | Address request |
| req_kind_i | input | 2 | Addressing kind |
| req_type_i | input | 3 | Operand type code |
| req_index_i | input | IDXW | Element index |
| req_mode_i | input | 2 | Scratchpad mode |
| ix_sel_i | input | 2 | Index register select for post-indexing |
| dest_i | input | 2 | Destination field of the instruction |
| wide_ptr_i | input | 1 | 64-bit pointers enabled |
| ix1_i | input | IXW | Index register 1 |
| ix2_i | input | IXW | Index register 2 |
| ix3_i | input | IXW | Index register 3 |
| mem_req_valid_o | output | 1 | Pointer read request |
| mem_req_ready_i | input | 1 | Pointer read accepted |
| mem_addr_o | output | AW | Pointer read address |
| mem_rsp_valid_i | input | 1 | Pointer data valid |
| mem_rsp_data_i | input | AW | Pointer data |
| busy_o | output | 1 | Indirect access in progress |
| done_o | output | 1 | Result valid pulse |
| err_o | output | 1 | Illegal type or kind, valid with done_o |
| supp_o | output | 1 | Operand is a supplementary register, valid with done_o |
| supp_idx_o | output | 6 | Supplementary register number |
| addr_o | output | AW | Final operand address |
| dest_o | output | 2 | Destination register |

## Verification
The bench uses the default parameters: 64-bit addresses, 32-bit index registers and an 8-bit index. With these values the upper word of 64-bit pointers and the 256-element index range are both exercised. Random pointer data with high bits set shows whether narrow pointers are truncated and wide ones kept. Index values above 63 in the narrow modes show whether the upper index bits are masked.

// File: rtl/spad_agen_pkg.sv
package spad_agen_pkg;
  typedef enum logic [1:0] {KIND_DIRECT = 2'd0, KIND_PTR = 2'd1, KIND_ARRAY = 2'd2, KIND_RSVD = 2'd3} kind_e;
  typedef enum logic [1:0] {MODE_STATELESS = 2'd0, MODE_STATEFUL = 2'd1, MODE_MUTABLE = 2'd2, MODE_REGPAD = 2'd3} mode_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2} seq_e;

  localparam int NUM_BANKS = 3;
  localparam int NUM_TYPES = 8;

  function automatic logic narrow_mode(input logic [1:0] m);
    return (m == MODE_STATELESS) || (m == MODE_REGPAD);
  endfunction

  // long, medium and quad are not encodable in the 64-element modes
  function automatic logic narrow_type_ok(input logic [2:0] t);
    return !(t == 3'd3 || t == 3'd4 || t == 3'd7);
  endfunction
endpackage

// File: rtl/spad_bank_file.sv
module spad_bank_file
  import spad_agen_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_bank_i,
  input  logic [2:0]    wr_type_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [1:0]    rd_bank_i,
  input  logic [2:0]    rd_type_i,
  output logic [AW-1:0] rd_data_o
);
  logic [AW-1:0] regs_q [NUM_BANKS][NUM_TYPES];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int t = 0; t < NUM_TYPES; t++) regs_q[b][t] <= '0;
      end else if (wr_en_i && wr_bank_i == 2'(b)) begin
        regs_q[b][wr_type_i] <= wr_data_i;
      end
    end
  end

  // same-cycle write bypass
  always_comb begin
    rd_data_o = '0;
    if (rd_bank_i < 2'(NUM_BANKS)) begin
      if (wr_en_i && wr_bank_i == rd_bank_i && wr_type_i == rd_type_i) rd_data_o = wr_data_i;
      else rd_data_o = regs_q[rd_bank_i][rd_type_i];
    end
  end
endmodule

// File: rtl/spad_offset_scale.sv
module spad_offset_scale #(
  parameter int AW = 64,
  parameter int IDXW = 8,
  parameter int SIDXW = 6,
  parameter logic [63:0] ELEM_BYTES = 64'h10_08_04_06_08_04_02_01
) (
  input  logic [IDXW-1:0] index_i,
  input  logic            narrow_i,
  input  logic [2:0]      type_i,
  input  logic            wide_i,
  output logic [AW-1:0]   elem_off_o,
  output logic [AW-1:0]   ptr_off_o
);
  localparam int PROD_W = IDXW + 8;

  logic [IDXW-1:0]   idx_eff;
  logic [7:0]        esize;
  logic [PROD_W-1:0] prod;

  always_comb begin
    idx_eff = index_i;
    if (narrow_i) idx_eff[IDXW-1:SIDXW] = '0;
    esize = ELEM_BYTES[{type_i, 3'b000} +: 8];
    prod  = PROD_W'(idx_eff) * PROD_W'(esize);
    elem_off_o = AW'(prod);
    ptr_off_o  = wide_i ? (AW'(idx_eff) << 3) : (AW'(idx_eff) << 2);
  end
endmodule

// File: rtl/spad_agen.sv
module spad_agen
  import spad_agen_pkg::*;
#(
  parameter int AW = 64,
  parameter int IXW = 32,
  parameter int PNW = 32,
  parameter int IDXW = 8,
  parameter int SIDXW = 6,
  parameter logic [63:0] ELEM_BYTES = 64'h10_08_04_06_08_04_02_01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_bank_i,
  input  logic [2:0]       wr_type_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  input  logic [2:0]       req_type_i,
  input  logic [IDXW-1:0]  req_index_i,
  input  logic [1:0]       req_mode_i,
  input  logic [1:0]       ix_sel_i,
  input  logic [1:0]       dest_i,
  input  logic             wide_ptr_i,
  input  logic [IXW-1:0]   ix1_i,
  input  logic [IXW-1:0]   ix2_i,
  input  logic [IXW-1:0]   ix3_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [AW-1:0]    mem_rsp_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             supp_o,
  output logic [SIDXW-1:0] supp_idx_o,
  output logic [AW-1:0]    addr_o,
  output logic [1:0]       dest_o
);
  seq_e          st_q;
  logic [AW-1:0] base, elem_off, ptr_off, ptr_val, ix_val;
  logic [AW-1:0] maddr_q, addr_q;
  logic          arr_q, wide_q, done_q, err_q, supp_q;
  logic [1:0]    ixsel_q, dest_q;
  logic [SIDXW-1:0] supp_idx_q;
  logic          narrow, bad, accept;

  assign narrow = narrow_mode(req_mode_i);
  assign bad    = (req_kind_i == KIND_RSVD) || (narrow && !narrow_type_ok(req_type_i));
  assign accept = req_valid_i && (st_q == ST_IDLE);

  spad_bank_file #(.AW(AW)) u_banks (
    .clk_i, .rst_ni, .wr_en_i, .wr_bank_i, .wr_type_i, .wr_data_i,
    .rd_bank_i(req_kind_i), .rd_type_i(req_type_i), .rd_data_o(base)
  );

  spad_offset_scale #(.AW(AW), .IDXW(IDXW), .SIDXW(SIDXW), .ELEM_BYTES(ELEM_BYTES)) u_scale (
    .index_i(req_index_i), .narrow_i(narrow), .type_i(req_type_i), .wide_i(wide_ptr_i),
    .elem_off_o(elem_off), .ptr_off_o(ptr_off)
  );

  always_comb begin
    ptr_val = wide_q ? mem_rsp_data_i : AW'(mem_rsp_data_i[PNW-1:0]);
    unique case (ixsel_q)
      2'd1:    ix_val = AW'(ix1_i);
      2'd2:    ix_val = AW'(ix2_i);
      2'd3:    ix_val = AW'(ix3_i);
      default: ix_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      maddr_q    <= '0;
      addr_q     <= '0;
      arr_q      <= 1'b0;
      wide_q     <= 1'b0;
      ixsel_q    <= '0;
      dest_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      supp_q     <= 1'b0;
      supp_idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      supp_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (bad) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            dest_q <= '0;
          end else if (req_kind_i == KIND_DIRECT) begin
            done_q <= 1'b1;
            dest_q <= dest_i;
            if (req_mode_i == MODE_REGPAD) begin
              supp_q     <= 1'b1;
              supp_idx_q <= req_index_i[SIDXW-1:0];
              addr_q     <= '0;
            end else begin
              addr_q <= base + elem_off;
            end
          end else begin
            st_q    <= ST_REQ;
            maddr_q <= base + ptr_off;
            arr_q   <= (req_kind_i == KIND_ARRAY);
            wide_q  <= wide_ptr_i;
            ixsel_q <= ix_sel_i;
          end
        end
        ST_REQ: if (mem_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          done_q <= 1'b1;
          dest_q <= '0;
          addr_q <= ptr_val + (arr_q ? ix_val : '0);
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (st_q == ST_REQ);
  assign mem_addr_o      = maddr_q;
  assign busy_o          = (st_q != ST_IDLE);
  assign done_o          = done_q;
  assign err_o           = err_q;
  assign supp_o          = supp_q;
  assign supp_idx_o      = supp_idx_q;
  assign addr_o          = addr_q;
  assign dest_o          = dest_q;
endmodule

// File: rtl/spad_agen_chk.sv
module spad_agen_chk #(
  parameter int AW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    req_kind_i,
  input logic [2:0]    req_type_i,
  input logic [1:0]    req_mode_i,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rsp_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          supp_o,
  input logic [1:0]    dest_o
);
  logic narrow_bad;
  assign narrow_bad = (req_mode_i == 2'd0 || req_mode_i == 2'd3) &&
                      (req_type_i == 3'd3 || req_type_i == 3'd4 || req_type_i == 3'd7);

  AST_DIRECT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o && req_kind_i == 2'd0 |=> done_o && !busy_o); // R3

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o)); // R4

  AST_INDIRECT_DEST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_req_valid_o && mem_rsp_valid_i |=> done_o && dest_o == 2'd0); // R6

  AST_ILLEGAL_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o && (narrow_bad || req_kind_i == 2'd3) |=> done_o && err_o && !mem_req_valid_o); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9

  AST_SUPP_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && supp_o |-> !err_o); // R7
endmodule

bind spad_agen spad_agen_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
  .req_type_i(req_type_i), .req_mode_i(req_mode_i), .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i), .mem_addr_o(mem_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .supp_o(supp_o), .dest_o(dest_o)
);

// File: tb/spad_agen_test.sv
module spad_agen_test;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 0, req_valid_i = 0, wide_ptr_i = 0;
  logic [1:0]  wr_bank_i = 0, req_kind_i = 0, req_mode_i = 0, ix_sel_i = 0, dest_i = 0;
  logic [2:0]  wr_type_i = 0, req_type_i = 0;
  logic [63:0] wr_data_i = 0, mem_addr_o, addr_o, mem_rsp_data_i = 0;
  logic [7:0]  req_index_i = 0;
  logic [31:0] ix1_i = 0, ix2_i = 0, ix3_i = 0;
  logic        mem_req_valid_o, mem_req_ready_i = 0, mem_rsp_valid_i = 0;
  logic        busy_o, done_o, err_o, supp_o;
  logic [5:0]  supp_idx_o;
  logic [1:0]  dest_o;

  int checks = 0, errors = 0;
  logic [63:0] bank_m [3][8];
  logic [63:0] last_paddr = 0, pend_addr = 0;
  logic        pend = 0;
  int          pend_cnt = 0;

  always #10 clk = ~clk;

  spad_agen uut (.clk_i(clk), .*);

  function automatic logic [63:0] memf(input logic [63:0] a);
    return {a[31:0] ^ 32'hC3A5_9617, ~a[31:0] + 32'h1357_9BDF};
  endfunction

  function automatic logic [63:0] esize(input logic [2:0] t);
    case (t)
      3'd0: return 1; 3'd1: return 2; 3'd2: return 4; 3'd3: return 8;
      3'd4: return 6; 3'd5: return 4; 3'd6: return 8; default: return 16;
    endcase
  endfunction

  // pointer memory model: random ready, response 1..3 cycles after handshake
  always @(negedge clk) mem_req_ready_i = ($urandom % 3) != 0;
  always @(posedge clk) begin
    if (mem_rsp_valid_i) mem_rsp_valid_i <= 1'b0;
    else if (pend && pend_cnt == 0) begin
      mem_rsp_valid_i <= 1'b1;
      mem_rsp_data_i  <= memf(pend_addr);
      pend <= 1'b0;
    end else if (pend) pend_cnt <= pend_cnt - 1;
    if (mem_req_valid_o && mem_req_ready_i) begin
      pend <= 1'b1; pend_cnt <= $urandom % 3;
      pend_addr <= mem_addr_o; last_paddr <= mem_addr_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input logic [2:0] t, input logic [63:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_bank_i = b; wr_type_i = t; wr_data_i = d;
    @(posedge clk); #1 wr_en_i = 0;
    bank_m[b][t] = d;
  endtask

  task automatic op(input logic [1:0] kind, input logic [2:0] typ, input logic [7:0] idx,
                    input logic [1:0] mode, input logic [1:0] ixs, input logic [1:0] dst,
                    input bit wide, input bit spam, input bit wsame, input logic [63:0] wd);
    bit narrow, bad, ind;
    logic [63:0] ie, pa, exp_addr, ixv;
    int n;
    narrow = (mode == 0 || mode == 3);
    ie = narrow ? 64'(idx[5:0]) : 64'(idx);
    bad = (kind == 3) || (narrow && (typ == 3 || typ == 4 || typ == 7));
    ind = !bad && kind != 0;
    @(negedge clk);
    if (wsame && kind != 3) begin
      wr_en_i = 1; wr_bank_i = kind; wr_type_i = typ; wr_data_i = wd;
      bank_m[kind][typ] = wd;
    end
    req_valid_i = 1; req_kind_i = kind; req_type_i = typ; req_index_i = idx;
    req_mode_i = mode; ix_sel_i = ixs; dest_i = dst; wide_ptr_i = wide;
    pa = 0; exp_addr = 0;
    if (ind) begin
      pa = bank_m[kind][typ] + ie * (wide ? 64'd8 : 64'd4);
      exp_addr = wide ? memf(pa) : {32'h0, memf(pa)[31:0]};
      ixv = (ixs == 1) ? 64'(ix1_i) : (ixs == 2) ? 64'(ix2_i) : (ixs == 3) ? 64'(ix3_i) : 64'd0;
      if (kind == 2) exp_addr = exp_addr + ixv;
    end else if (!bad && mode != 3) exp_addr = bank_m[0][typ] + ie * esize(typ);
    @(posedge clk); #1;
    wr_en_i = 0;
    if (spam && ind) req_kind_i = 0; else req_valid_i = 0;
    n = 0;
    while (n < 40) begin
      @(negedge clk); n++;
      req_valid_i = 0;
      if (n == 1 && ind) chk(busy_o == 1, "R9 busy after indirect accept", 64'(busy_o), 1);
      if (done_o) break;
    end
    chk(done_o == 1, "R9 done reached", 64'(done_o), 1);
    if (!ind) chk(n == 1, "R3 one-cycle latency", 64'(n), 1);
    chk(err_o == bad, "R8 err flag", 64'(err_o), 64'(bad));
    if (!bad) begin
      if (kind == 0 && mode == 3) begin
        chk(supp_o == 1, "R7 supp flag", 64'(supp_o), 1);
        chk(supp_idx_o == idx[5:0], "R7 supp index", 64'(supp_idx_o), 64'(idx[5:0]));
      end else begin
        chk(supp_o == 0, "R7 no supp", 64'(supp_o), 0);
        chk(addr_o == exp_addr, kind == 0 ? "R3 direct addr" : kind == 1 ? "R4 R10 indirect addr" : "R5 R10 post-indexed addr",
            addr_o, exp_addr);
      end
      chk(dest_o == (kind == 0 ? dst : 2'd0), "R6 dest", 64'(dest_o), 64'(kind == 0 ? dst : 2'd0));
    end
    if (ind) chk(last_paddr == pa, kind == 1 ? "R4 fetch addr" : "R5 fetch addr", last_paddr, pa);
    @(negedge clk);
    chk(done_o == 0 && busy_o == 0, "R9 single pulse", 64'({done_o, busy_o}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    for (int b = 0; b < 3; b++) for (int t = 0; t < 8; t++) bank_m[b][t] = 0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && mem_req_valid_o == 0, "R12 reset outputs", 64'({busy_o, done_o, mem_req_valid_o}), 0);
    rst_ni = 1;
    ix1_i = 32'hFFFF_FFF0; ix2_i = 32'h0000_1000; ix3_i = 32'h8000_0001;
    // R12: banks cleared by reset
    op(0, 2, 8'd5, 1, 0, 0, 0, 0, 0, 0);
    // R1 R3: distinct bases per type
    for (int t = 0; t < 8; t++) begin
      wr(0, 3'(t), 64'h1000_0000 * (t + 1));
      wr(1, 3'(t), 64'h2_0000_0000 + 64'h100 * t);
      wr(2, 3'(t), 64'h3_0000_0000 + 64'h200 * t);
    end
    op(0, 4, 8'hFF, 1, 0, 3, 0, 0, 0, 0);   // R2 full index, medium size 6
    op(0, 6, 8'hC5, 0, 0, 2, 0, 0, 0, 0);   // R2 upper bits masked
    op(0, 3, 8'd1, 0, 0, 1, 0, 0, 0, 0);    // R8 long in stateless
    op(1, 7, 8'd2, 3, 0, 0, 0, 0, 0, 0);    // R8 quad in register mode
    op(3, 0, 8'd0, 1, 0, 0, 0, 0, 0, 0);    // R8 reserved kind
    op(0, 1, 8'hE7, 3, 0, 2, 0, 0, 0, 0);   // R7 supplementary register
    op(1, 5, 8'd9, 3, 0, 3, 0, 0, 0, 0);    // R7 indirect still fetches
    op(1, 2, 8'hA0, 1, 0, 3, 0, 0, 0, 0);   // R4 R10 narrow pointer
    op(1, 2, 8'hA0, 2, 0, 3, 1, 0, 0, 0);   // R10 wide pointer
    op(2, 6, 8'd17, 1, 1, 1, 1, 0, 0, 0);   // R5 ix1
    op(2, 0, 8'd3, 0, 3, 0, 0, 0, 0, 0);    // R5 ix3
    op(2, 5, 8'd3, 2, 0, 0, 0, 0, 0, 0);    // R5 sel 0 adds nothing
    op(1, 1, 8'd4, 1, 0, 0, 1, 1, 0, 0);    // R9 request while busy ignored
    wr(0, 5, 64'hABCD_0000);
    op(0, 5, 8'd7, 1, 0, 1, 0, 0, 0, 0);    // R11 next-cycle read
    op(1, 6, 8'd7, 1, 0, 0, 1, 0, 1, 64'h4_4444_0000); // R11 same-cycle bypass
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 2) wr(2'($urandom % 3), 3'($urandom), {$urandom, $urandom});
      op(2'($urandom), 3'($urandom), 8'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
         1'($urandom), 1'($urandom), 1'($urandom), {$urandom, $urandom});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule